// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Tracking

This block takes an asynchronous serial line and turns it into characters. A 16x baud enable, produced outside the block, paces the sampling. Each character frame has a start bit, 5 to 8 data bits sent LSB first, an optional parity bit and a stop bit. The block stores each finished character in a receive FIFO along with three error bits: parity, framing and break. A consumer reads the FIFO through a pop strobe. The fields of the oldest entry appear at the read port together with the line-status flags.

The frame format comes from static control inputs: the word length, a parity enable and a 2-bit parity mode. Software sets these while the line is idle. Besides the flags of the head entry, the block reports two more flags. A sticky overrun flag shows that a character was lost. A summary flag is high while any stored character carries an error.

Top module: `uart_rx_deser`

## Requirements
- R1: `wlen_i` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits arrive LSB first, and a character shorter than 8 bits is read out with its upper bits set to zero.
- R2: A low level on the line starts a frame only if it is still low at the 8th baud enable after it was first seen. Otherwise the receiver returns to idle and stores nothing.
- R3: With `par_en_i` high and `par_mode_i` 00 (odd) or 01 (even), one parity bit follows the data. The parity flag is set when the data bits and the parity bit together have an even count of ones in odd mode, or an odd count in even mode.
- R4: With `par_en_i` high and `par_mode_i` 10 or 11, the parity bit must be 1 or 0 respectively. Any other value sets the parity flag.
- R5: With `par_en_i` low, the stop bit comes straight after the data and the parity flag is never set.
- R6: The framing flag is set when the first stop bit is sampled low. Any further stop bits are not checked.
- R7: A frame that is low in every sampled position, stop bit included, is stored as data 0x00 with the break and framing flags set and the parity flag clear. The receiver then starts no new frame until the line has gone high again.
- R8: Characters are read in arrival order. `data_ready_o` is high while the FIFO holds at least one entry. A one-cycle `rd_i` pulse removes the head entry. While no read happens, the head data does not change.
- R9: A character that completes while the FIFO is full and no read happens in that cycle is dropped and sets `overrun_o`. `overrun_o` stays set until the next read of a non-empty FIFO.
- R10: `rx_err_any_o` is high exactly when at least one stored entry has its parity, framing or break flag set.
- R11: After reset the FIFO is empty. `rd_data_o` reads 0x00, and every flag output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idles high |
| baud_tick_i | input | 1 | Enable pulse at 16 times the bit rate |
| wlen_i | input | 2 | Data bit count code |
| par_en_i | input | 1 | Parity bit present |
| par_mode_i | input | 2 | Parity rule: odd, even, force 1, force 0 |
| rd_i | input | 1 | Pop the head entry |
| rd_data_o | output | 8 | Head character, zero-extended |
| data_ready_o | output | 1 | FIFO not empty |
| overrun_o | output | 1 | Sticky: a character was dropped |
| parity_err_o | output | 1 | Head entry has a parity error |
| framing_err_o | output | 1 | Head entry has a framing error |
| break_o | output | 1 | Head entry is a break |
| rx_err_any_o | output | 1 | Some stored entry has an error |

## Verification
The bench sends a short low glitch. A receiver that skips the mid-bit recheck would store a phantom character. It holds the line low for much longer than a frame. A receiver that restarts while the line is still low would queue a second break, and one that does not suppress parity on a break would flag a parity error. It fills the FIFO one character past capacity and checks that the first sixteen characters survive in order. A design that overwrites the newest entry or never clears the overrun would fail there. It also checks that the summary flag stays set until the errored entry itself is popped. A counter that tracked only the head entry would drop the flag too early.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAIT
  } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rxd_i,
  input  logic      tick_i,
  input  logic [1:0] wlen_i,
  input  logic      par_en_i,
  input  logic [1:0] par_mode_i,
  output logic      push_o,
  output rx_entry_t entry_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OVS / 2 - 1);

  rx_state_t         state_q;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              acc_q, hi_q, pbit_q;
  logic              last_bit, exp_par, bit_end;

  assign last_bit = (idx_q == (3'd4 + {1'b0, wlen_i}));
  assign bit_end  = (cnt_q == CNT_LAST);

  always_comb begin
    unique case (par_mode_i)
      2'b00:   exp_par = ~acc_q;
      2'b01:   exp_par = acc_q;
      2'b10:   exp_par = 1'b1;
      default: exp_par = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      hi_q    <= 1'b0;
      pbit_q  <= 1'b0;
      push_o  <= 1'b0;
      entry_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rxd_i) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
          ST_START: begin
            if (cnt_q == CNT_MID) begin
              // mid-bit recheck rejects glitches
              if (!rxd_i) begin
                state_q <= ST_DATA;
                cnt_q   <= '0;
                idx_q   <= '0;
                sh_q    <= '0;
                acc_q   <= 1'b0;
                hi_q    <= 1'b0;
                pbit_q  <= 1'b0;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (bit_end) begin
              cnt_q       <= '0;
              sh_q[idx_q] <= rxd_i;
              acc_q       <= acc_q ^ rxd_i;
              hi_q        <= hi_q | rxd_i;
              if (last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else          idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (bit_end) begin
              cnt_q   <= '0;
              pbit_q  <= rxd_i;
              hi_q    <= hi_q | rxd_i;
              state_q <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (bit_end) begin
              cnt_q        <= '0;
              push_o       <= 1'b1;
              entry_o.data <= sh_q;
              entry_o.frm  <= ~rxd_i;
              entry_o.brk  <= ~rxd_i & ~hi_q;
              entry_o.par  <= par_en_i & ~(~rxd_i & ~hi_q) & (pbit_q != exp_par);
              state_q      <= rxd_i ? ST_IDLE : ST_WAIT;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WAIT: if (rxd_i) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  rx_entry_t entry_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic      empty_o,
  output logic      overrun_o,
  output logic      err_any_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  rx_entry_t     mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, ecnt_q;
  logic          full, do_pop, do_push, err_in, err_out;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNT_FULL);
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full | do_pop);
  assign head_o  = mem_q[rd_q];
  assign err_in  = do_push & (entry_i.par | entry_i.frm | entry_i.brk);
  assign err_out = do_pop & (head_o.par | head_o.frm | head_o.brk);
  assign err_any_o = (ecnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= '0;
      rd_q      <= '0;
      cnt_q     <= '0;
      ecnt_q    <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      cnt_q  <= cnt_q + CW'(do_push) - CW'(do_pop);
      ecnt_q <= ecnt_q + CW'(err_in) - CW'(err_out);
      if (do_pop)                     overrun_o <= 1'b0;
      else if (push_i && full)        overrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  input  logic       baud_tick_i,
  input  logic [1:0] wlen_i,
  input  logic       par_en_i,
  input  logic [1:0] par_mode_i,
  input  logic       rd_i,
  output logic [7:0] rd_data_o,
  output logic       data_ready_o,
  output logic       overrun_o,
  output logic       parity_err_o,
  output logic       framing_err_o,
  output logic       break_o,
  output logic       rx_err_any_o
);
  logic      rxd_s, push, empty;
  rx_entry_t entry, head;

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_i(rxd_s), .tick_i(baud_tick_i),
    .wlen_i(wlen_i), .par_en_i(par_en_i), .par_mode_i(par_mode_i),
    .push_o(push), .entry_o(entry)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .entry_i(entry),
    .pop_i(rd_i), .head_o(head), .empty_o(empty),
    .overrun_o(overrun_o), .err_any_o(rx_err_any_o)
  );

  assign data_ready_o  = ~empty;
  assign rd_data_o     = empty ? '0 : head.data;
  assign parity_err_o  = ~empty & head.par;
  assign framing_err_o = ~empty & head.frm;
  assign break_o       = ~empty & head.brk;
endmodule

// File: rtl/uart_rx_deser_chk.sv
module uart_rx_deser_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic [7:0] rd_data_o,
  input logic       data_ready_o,
  input logic       overrun_o,
  input logic       parity_err_o,
  input logic       framing_err_o,
  input logic       break_o,
  input logic       rx_err_any_o
);
  // R7
  brk_has_frm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> (framing_err_o && !parity_err_o && rd_data_o == 8'h00));
  // R8
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && data_ready_o) |=> (data_ready_o && $stable(rd_data_o)));
  // R9
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && data_ready_o) |=> !overrun_o);
  // R9
  ovr_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> data_ready_o);
  // R10
  head_err_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parity_err_o || framing_err_o || break_o) |-> rx_err_any_o);
  // R10
  sum_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_any_o |-> data_ready_o);
endmodule

bind uart_rx_deser uart_rx_deser_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .rd_data_o(rd_data_o),
  .data_ready_o(data_ready_o), .overrun_o(overrun_o),
  .parity_err_o(parity_err_o), .framing_err_o(framing_err_o),
  .break_o(break_o), .rx_err_any_o(rx_err_any_o)
);

// File: tb/uart_rx_deser_tb.sv
module uart_rx_deser_tb;
  localparam int BIT_CLK = 64;
  localparam int DEPTH   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, tick = 1'b0, rd = 1'b0, pen = 1'b0;
  logic [1:0] wlen = 2'b11, pmode = 2'b00, tdiv = 2'b00;
  logic [7:0] rdata;
  logic dr, ovr, pe, fe, bi, eany;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  uart_rx_deser #(.OVS(16), .DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .baud_tick_i(tick),
    .wlen_i(wlen), .par_en_i(pen), .par_mode_i(pmode), .rd_i(rd),
    .rd_data_o(rdata), .data_ready_o(dr), .overrun_o(ovr),
    .parity_err_o(pe), .framing_err_o(fe), .break_o(bi), .rx_err_any_o(eany)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input int nb, input logic [1:0] m);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    case (m)
      2'b00:   return ~x;
      2'b01:   return x;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic hold(input logic v, input int bits);
    rxd = v;
    repeat (bits * BIT_CLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input logic pb, input logic stopv);
    hold(1'b0, 1);
    for (int i = 0; i < nb; i++) hold(d[i], 1);
    if (pen) hold(pb, 1);
    hold(stopv, 1);
    hold(1'b1, 2);
  endtask

  task automatic pop_expect(input logic [7:0] d, input logic epe, input logic efe,
                            input logic ebi, input string req);
    chk(dr == 1'b1, {req, " ready"}, dr, 1);
    chk(rdata == d, {req, " data"}, rdata, d);
    chk({pe, fe, bi} == {epe, efe, ebi}, {req, " flags"}, {pe, fe, bi}, {epe, efe, ebi});
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset();
    chk({dr, ovr, pe, fe, bi, eany} == 6'b0, "R11 flags", {dr, ovr, pe, fe, bi, eany}, 0);
    chk(rdata == 8'h00, "R11 data", rdata, 0);
  endtask

  task automatic t_wlen();
    pen = 1'b0;
    for (int w = 0; w < 4; w++) begin
      wlen = 2'(w);
      send(8'hF5, 5 + w, 1'b0, 1'b1);
      pop_expect(8'hF5 & 8'((1 << (5 + w)) - 1), 0, 0, 0, "R1 wlen");
    end
    wlen = 2'b11;
  endtask

  task automatic t_parity();
    pen = 1'b1;
    for (int m = 0; m < 4; m++) begin
      pmode = 2'(m);
      send(8'h96, 8, par_of(8'h96, 8, pmode), 1'b1);
      pop_expect(8'h96, 0, 0, 0, m < 2 ? "R3 good" : "R4 good");
      send(8'h37, 8, ~par_of(8'h37, 8, pmode), 1'b1);
      pop_expect(8'h37, 1, 0, 0, m < 2 ? "R3 bad" : "R4 bad");
    end
    wlen = 2'b01;
    pmode = 2'b00;
    send(8'h2B, 6, ~par_of(8'h2B, 6, 2'b00), 1'b1);
    pop_expect(8'h2B, 1, 0, 0, "R3 short word");
    wlen = 2'b11;
    pen = 1'b0;
  endtask

  task automatic t_nopar();
    pen = 1'b0;
    send(8'h01, 8, 1'b0, 1'b1);
    send(8'hFE, 8, 1'b0, 1'b1);
    pop_expect(8'h01, 0, 0, 0, "R5 first");
    pop_expect(8'hFE, 0, 0, 0, "R5 second");
    chk(dr == 1'b0, "R5 count", dr, 0);
  endtask

  task automatic t_glitch();
    rxd = 1'b0;
    repeat (12) @(negedge clk);
    hold(1'b1, 12);
    chk(dr == 1'b0, "R2 glitch ignored", dr, 0);
  endtask

  task automatic t_framing();
    send(8'h5A, 8, 1'b0, 1'b0);
    pop_expect(8'h5A, 0, 1, 0, "R6 stop low");
  endtask

  task automatic t_break();
    pen = 1'b1;
    pmode = 2'b00;
    hold(1'b0, 14);
    hold(1'b1, 2);
    pop_expect(8'h00, 0, 1, 1, "R7 break");
    chk(dr == 1'b0, "R7 single entry", dr, 0);
    pen = 1'b0;
    send(8'hC3, 8, 1'b0, 1'b1);
    pop_expect(8'hC3, 0, 0, 0, "R7 resume");
  endtask

  task automatic t_order_overrun();
    for (int i = 0; i <= DEPTH; i++) send(8'(i * 7 + 3), 8, 1'b0, 1'b1);
    chk(ovr == 1'b1, "R9 overrun set", ovr, 1);
    pop_expect(8'd3, 0, 0, 0, "R9 oldest kept");
    chk(ovr == 1'b0, "R9 overrun cleared", ovr, 0);
    for (int i = 1; i < DEPTH; i++) pop_expect(8'(i * 7 + 3), 0, 0, 0, "R8 order");
    chk(dr == 1'b0, "R9 newest dropped", dr, 0);
  endtask

  task automatic t_summary();
    send(8'h11, 8, 1'b0, 1'b1);
    send(8'h22, 8, 1'b0, 1'b0);
    send(8'h33, 8, 1'b0, 1'b1);
    chk(eany == 1'b1, "R10 set", eany, 1);
    pop_expect(8'h11, 0, 0, 0, "R10 clean head");
    chk(eany == 1'b1, "R10 still held", eany, 1);
    pop_expect(8'h22, 0, 1, 0, "R10 bad head");
    chk(eany == 1'b0, "R10 cleared", eany, 0);
    pop_expect(8'h33, 0, 0, 0, "R10 tail");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_wlen();
    t_parity();
    t_nopar();
    t_glitch();
    t_framing();
    t_break();
    t_order_overrun();
    t_summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule